// File: doc/BRIEF.md
# Accumulator Multi-Position Shift and Rotate Unit

This block shifts or rotates a 16-bit accumulator value by any amount from 0 to 15 positions in a single operation. The kind of operation and the shift amount are both encoded in the 16-bit instruction word. A 12-position left shift or a 15-position left rotate therefore takes one instruction word and no loop.

For shifts by an amount known only at run time, one instruction bit selects the low four bits of the X register as the amount. The field in the instruction word is then not used.

The datapath is combinational. When `issue_en` is high, the next clock edge registers the result and the N, Z and carry flags. When `issue_en` is low, all outputs hold their values.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer inside the block.

Top module: `acc_shift_unit`

## Requirements
- R1: The instruction word is decoded as follows. Bits [3:0] hold the amount. Bits [5:4] select the operation: 00 is shift left, 01 is shift right, 10 is rotate left and 11 is rotate right. Bit 6 selects the amount source: 0 uses the field and 1 uses the X register. Bits [15:7] are ignored. The outputs update at the first rising clock edge where `issue_en` is high.
- R2: A shift left by n (n from 1 to 15) fills the vacated low bits with zeros. The carry flag becomes input bit 16-n.
- R3: A shift right by n (n from 1 to 15) is logical: it fills the vacated high bits with zeros. The carry flag becomes input bit n-1.
- R4: A rotate left by n is circular within 16 bits. Result bit i equals input bit (i-n) mod 16. The carry flag is loaded with `carry_in`, unchanged.
- R5: A rotate right by n is circular within 16 bits. Result bit i equals input bit (i+n) mod 16. The carry flag is loaded with `carry_in`, unchanged.
- R6: An amount of zero, for any operation, registers `acc_in` unchanged and loads the carry flag with `carry_in`.
- R7: When bit 6 is 1, the amount is `x_reg[3:0]`. Bits [15:4] of `x_reg` and bits [3:0] of the instruction word are then ignored.
- R8: `flag_n` equals bit 15 of the registered result. `flag_z` is 1 exactly when all 16 result bits are zero.
- R9: While `issue_en` is low, `result` and all three flags keep their values, whatever the other inputs do.
- R10: While reset is asserted, `result`, `flag_n`, `flag_z` and `flag_c` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_en | input | 1 | Register a new result at this edge |
| instr_word | input | 16 | Instruction word carrying the operation, amount and amount source |
| x_reg | input | 16 | X register; its low four bits can supply the amount |
| acc_in | input | 16 | Accumulator operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Registered shift or rotate result |
| flag_n | output | 1 | Negative flag (result bit 15) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every issued operation is visible at the ports one edge later, so a faulty stage in the shift network shows up at once. A stage stuck on or off appears as a result off by a power-of-two amount, but only for amounts that use that stage. The directed amounts therefore cover each amount bit both alone and in combination.

A bad carry-slot path appears only in `flag_c`, and only for non-zero shifts. A broken reversal for right operations shows as a mirrored result.

A wrong amount-source select shows only when the field and the low bits of X differ. The bench therefore always drives conflicting values in the two places.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  // Operation codes carried in instruction bits [5:4]
  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_ROL = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;

  typedef struct packed {
    logic rotate;
    logic right;
  } shift_ctl_t;

  function automatic shift_ctl_t op_to_ctl(input shift_op_e op);
    shift_ctl_t c;
    c.rotate = (op == OP_ROL) || (op == OP_ROR);
    c.right  = (op == OP_SHR) || (op == OP_ROR);
    return c;
  endfunction

endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int X_W     = 16,
  parameter int CNT_W   = 4
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [X_W-1:0]     x_val,
  output shift_ctl_t         ctl,
  output logic [CNT_W-1:0]   amount
);

  localparam int OP_LSB  = CNT_W;
  localparam int SRC_BIT = CNT_W + 2;

  shift_op_e op;
  logic      from_x;

  always_comb begin
    op     = shift_op_e'(instr[OP_LSB +: 2]);
    from_x = instr[SRC_BIT];
    ctl    = op_to_ctl(op);
    if (from_x) begin
      amount = x_val[CNT_W-1:0];
    end else begin
      amount = instr[CNT_W-1:0];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{instr[INSTR_W-1:SRC_BIT+1], x_val[X_W-1:CNT_W]};

endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic              carry_in,
  input  logic [CNT_W-1:0]  amount,
  input  logic              rotate,
  input  logic              right,
  output logic [DATA_W-1:0] data_out,
  output logic              carry_out
);

  // Each stage holds {carry slot, data}; right operations run on reversed data
  logic [DATA_W:0] stage [CNT_W+1];

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) begin
      r[i] = v[DATA_W-1-i];
    end
    return r;
  endfunction

  assign stage[0] = {carry_in, right ? flip(data_in) : data_in};

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [DATA_W:0] nxt;
    always_comb begin
      if (!amount[k]) begin
        nxt = stage[k];
      end else if (rotate) begin
        nxt = {stage[k][DATA_W],
               stage[k][DATA_W-1-SH:0],
               stage[k][DATA_W-1 -: SH]};
      end else begin
        nxt = {stage[k][DATA_W-SH:0], {SH{1'b0}}};
      end
    end
    assign stage[k+1] = nxt;
  end

  always_comb begin
    carry_out = stage[CNT_W][DATA_W];
    if (right) begin
      data_out = flip(stage[CNT_W][DATA_W-1:0]);
    end else begin
      data_out = stage[CNT_W][DATA_W-1:0];
    end
  end

endmodule

// File: rtl/acc_shift_flags.sv
module acc_shift_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  output logic              neg,
  output logic              zero
);

  always_comb begin
    neg  = value[DATA_W-1];
    zero = ~|value;
  end

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int INSTR_W = 16,
  parameter int CNT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0] x_reg,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c
);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  shift_ctl_t        ctl;
  logic [CNT_W-1:0]  amount;
  logic [DATA_W-1:0] shifted;
  logic              carry_calc;
  logic              n_calc;
  logic              z_calc;

  acc_shift_decode #(
    .INSTR_W (INSTR_W),
    .X_W     (DATA_W),
    .CNT_W   (CNT_W)
  ) u_decode (
    .instr  (instr_word),
    .x_val  (x_reg),
    .ctl    (ctl),
    .amount (amount)
  );

  acc_shift_core #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_core (
    .data_in   (acc_in),
    .carry_in  (carry_in),
    .amount    (amount),
    .rotate    (ctl.rotate),
    .right     (ctl.right),
    .data_out  (shifted),
    .carry_out (carry_calc)
  );

  acc_shift_flags #(
    .DATA_W (DATA_W)
  ) u_flags (
    .value (shifted),
    .neg   (n_calc),
    .zero  (z_calc)
  );

  // Next-state logic with written-out clock enable
  logic [DATA_W-1:0] result_d;
  logic              n_d, z_d, c_d;

  always_comb begin
    result_d = result;
    n_d      = flag_n;
    z_d      = flag_z;
    c_d      = flag_c;
    if (issue_en) begin
      result_d = shifted;
      n_d      = n_calc;
      z_d      = z_calc;
      c_d      = carry_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      result <= result_d;
      flag_n <= n_d;
      flag_z <= z_d;
      flag_c <= c_d;
    end
  end

  // Checker arming: set one edge after reset release so $past never sees reset-time values
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      chk_armed <= 1'b0;
    end else begin
      chk_armed <= 1'b1;
    end
  end

  assert_zero_amount_identity_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && $past(issue_en) && ($past(amount) == '0))
      |-> (result == $past(acc_in)) && (flag_c == $past(carry_in)));

  assert_rotate_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && $past(issue_en) && $past(ctl.rotate))
      |-> (flag_c == $past(carry_in)) && ($countones(result) == $countones($past(acc_in))));

  assert_left_shift_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && $past(issue_en) && !$past(ctl.rotate) && !$past(ctl.right) && ($past(amount) != '0))
      |-> (result[0] == 1'b0));

  assert_right_shift_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && $past(issue_en) && !$past(ctl.rotate) && $past(ctl.right) && ($past(amount) != '0))
      |-> (result[DATA_W-1] == 1'b0));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && !$past(issue_en))
      |-> $stable(result) && $stable(flag_n) && $stable(flag_z) && $stable(flag_c));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chk_armed && $past(issue_en)) |-> (flag_n == result[DATA_W-1]) && (flag_z == (result == '0)));

endmodule

// File: tb/tb_acc_shift_unit.sv
`timescale 1ns/1ps
module tb_acc_shift_unit;

  logic        clk;
  logic        rst_n;
  logic        issue_en;
  logic [15:0] instr_word;
  logic [15:0] x_reg;
  logic [15:0] acc_in;
  logic        carry_in;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_c;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  acc_shift_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_en   (issue_en),
    .instr_word (instr_word),
    .x_reg      (x_reg),
    .acc_in     (acc_in),
    .carry_in   (carry_in),
    .result     (result),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model built from the requirements, bit by bit
  function automatic logic [16:0] model(input logic [1:0] op, input int n,
                                        input logic [15:0] a, input logic cin);
    logic [15:0] r;
    logic        c;
    for (int i = 0; i < 16; i++) begin
      case (op)
        2'b00: r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
        2'b01: r[i] = (i + n < 16) ? a[i+n] : 1'b0;
        2'b10: r[i] = a[(i - n + 16) % 16];
        default: r[i] = a[(i + n) % 16];
      endcase
    end
    if (n == 0 || op[1]) c = cin;
    else if (op == 2'b00) c = a[16-n];
    else c = a[n-1];
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [15:0] exp_r, input logic exp_n,
                       input logic exp_z, input logic exp_c);
    n_checks++;
    if (result !== exp_r || flag_n !== exp_n || flag_z !== exp_z || flag_c !== exp_c) begin
      n_fails++;
      $display("FAIL %s: actual r=%h n=%b z=%b c=%b expected r=%h n=%b z=%b c=%b",
               req, result, flag_n, flag_z, flag_c, exp_r, exp_n, exp_z, exp_c);
    end
  endtask

  task automatic issue(input logic [15:0] instr, input logic [15:0] x,
                       input logic [15:0] a, input logic cin);
    @(negedge clk);
    instr_word = instr;
    x_reg      = x;
    acc_in     = a;
    carry_in   = cin;
    issue_en   = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    issue_en = 1'b0;
  endtask

  function automatic logic [15:0] mk(input logic [8:0] junk, input logic src,
                                     input logic [1:0] op, input logic [3:0] cnt);
    return {junk, src, op, cnt};
  endfunction

  task automatic run_op(input string req, input logic [1:0] op, input int n,
                        input logic [15:0] a, input logic cin);
    logic [16:0] e;
    e = model(op, n, a, cin);
    issue(mk(9'h1A5, 1'b0, op, 4'(n)), 16'hFFF0 | 16'(~n & 15), a, cin);
    check(req, e[15:0], e[15], e[15:0] == 16'h0, e[16]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    issue_en = 1'b0;
    instr_word = '0;
    x_reg = '0;
    acc_in = 16'hFFFF;
    carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 reset", 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R10 after release", 16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_shift_left;
    run_op("R2 shl12", 2'b00, 12, 16'h8421, 1'b0);
    run_op("R2 shl1",  2'b00, 1,  16'h8001, 1'b0);
    run_op("R2 shl15", 2'b00, 15, 16'h5555, 1'b1);
    run_op("R2 shl5",  2'b00, 5,  16'hF0F0, 1'b0);
    run_op("R1 shl4",  2'b00, 4,  16'h1234, 1'b1);
  endtask

  task automatic t_shift_right;
    run_op("R3 shr1",  2'b01, 1,  16'h8003, 1'b0);
    run_op("R3 shr15", 2'b01, 15, 16'hFFFF, 1'b0);
    run_op("R3 shr7",  2'b01, 7,  16'hA5C3, 1'b1);
    run_op("R3 shr8",  2'b01, 8,  16'h00FF, 1'b0);
  endtask

  task automatic t_rotate_left;
    run_op("R4 rol15", 2'b10, 15, 16'h8001, 1'b0);
    run_op("R4 rol3",  2'b10, 3,  16'hE001, 1'b1);
    run_op("R4 rol10", 2'b10, 10, 16'h1234, 1'b0);
  endtask

  task automatic t_rotate_right;
    run_op("R5 ror1",  2'b11, 1,  16'h0001, 1'b0);
    run_op("R5 ror9",  2'b11, 9,  16'hBEEF, 1'b1);
    run_op("R5 ror15", 2'b11, 15, 16'h4000, 1'b0);
  endtask

  task automatic t_zero_amount;
    for (int op = 0; op < 4; op++) begin
      run_op("R6 zero amount", 2'(op), 0, 16'h9C3A, op[0]);
    end
  endtask

  task automatic t_x_amount;
    logic [16:0] e;
    // field says 2, X low bits say 11, X upper bits are noise
    e = model(2'b00, 11, 16'h0F37, 1'b0);
    issue(mk(9'h0FF, 1'b1, 2'b00, 4'd2), 16'hABCB, 16'h0F37, 1'b0);
    check("R7 x shl", e[15:0], e[15], e[15:0] == 16'h0, e[16]);
    e = model(2'b11, 6, 16'h8137, 1'b1);
    issue(mk(9'h000, 1'b1, 2'b11, 4'd15), 16'h5556, 16'h8137, 1'b1);
    check("R7 x ror", e[15:0], e[15], e[15:0] == 16'h0, e[16]);
    e = model(2'b01, 0, 16'h7001, 1'b1);
    issue(mk(9'h1FF, 1'b1, 2'b01, 4'd9), 16'hFFF0, 16'h7001, 1'b1);
    check("R7 x zero", e[15:0], e[15], e[15:0] == 16'h0, e[16]);
  endtask

  task automatic t_flags;
    run_op("R8 zero result",  2'b00, 8, 16'h00FF >> 0 & 16'hFF00 | 16'h0000, 1'b1);
    run_op("R8 shl to zero",  2'b00, 8, 16'hFF00, 1'b0);
    run_op("R8 negative",     2'b10, 1, 16'h4000, 1'b0);
    run_op("R8 zero operand", 2'b11, 5, 16'h0000, 1'b1);
  endtask

  task automatic t_hold;
    logic [16:0] e;
    e = model(2'b10, 4, 16'h8F01, 1'b1);
    issue(mk(9'h000, 1'b0, 2'b10, 4'd4), 16'h0, 16'h8F01, 1'b1);
    check("R9 setup", e[15:0], e[15], e[15:0] == 16'h0, e[16]);
    @(negedge clk);
    issue_en   = 1'b0;
    instr_word = mk(9'h000, 1'b0, 2'b01, 4'd3);
    acc_in     = 16'h0000;
    carry_in   = 1'b0;
    x_reg      = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 check("R9 hold", e[15:0], e[15], e[15:0] == 16'h0, e[16]);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_shift_left();
    t_shift_right();
    t_rotate_left();
    t_rotate_right();
    t_zero_amount();
    t_x_amount();
    t_flags();
    t_hold();
    finish_run();
  end

endmodule